// File: doc/BRIEF.md
# Calibration Coefficient Register Bank

This block stores the offset and gain correction words for a two-channel converter. The host reaches these words through a serial port. Before a frame starts, the host sets the channel, the register kind (offset or gain) and the direction. It then lowers the select line and clocks 24 bits, most significant bit first, one bit per shift strobe. A write is kept only when all 24 bits arrive while the converter is in its normal mode. A write that stops early leaves the register unchanged.

A completed write goes into staging storage and raises a pending flag for that channel. The active coefficients are a parallel output for the arithmetic that applies them. They change only when the conversion engine pulses its acquisition-start strobe for that channel while the sync-hold input is low. At that boundary the staged words are copied to the active set, and the channel's discard flag rises. The discard flag marks the result of that first acquisition as unusable.

Top module: `cal_bank`

## Requirements
- R1: After reset, every active and staged offset word is 0x000000, every gain word is 0x800000, and all pending and discard flags are 0.
- R2: While ser_cs_n is low, each ser_stb cycle shifts in ser_din, most significant bit first. The 24th bit completes the frame. If ser_wr is 1, the word is stored in the register chosen by sel_ch (channel number) and sel_gain (1 = gain, 0 = offset), and pending[sel_ch] is set.
- R3: Raising ser_cs_n before 24 bits have arrived stores nothing and leaves pending unchanged. It also clears the bit count, so the next frame starts again from bit 0.
- R4: A frame that completes while mode_normal is 0 stores nothing and sets no pending flag.
- R5: A staged word reaches act_off or act_gain only on an accepted acquisition start for its channel. Until then the active word keeps its old value. Channel c occupies bits [24c+23:24c] of each output bus.
- R6: An acq_start pulse while sync_hold is 1 is ignored. Active words, pending flags and discard flags all keep their values.
- R7: An accepted acq_start for a channel with pending set copies that channel's staged words to its active words, clears pending, and sets discard for that channel. The next accepted start for that channel with nothing pending clears discard.
- R8: During a read frame, ser_dout shows bit 23-k of the selected word before the k-th strobe. That word is the staged value if the channel is pending, and the active value otherwise.
- R9: An acquisition start for one channel leaves the other channel's active words and pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_stb | input | 1 | One-cycle shift strobe (serial clock rising edge) |
| ser_din | input | 1 | Serial write data |
| ser_dout | output | 1 | Serial read data |
| sel_ch | input | 1 | Target channel |
| sel_gain | input | 1 | 1 selects the gain word, 0 the offset word |
| ser_wr | input | 1 | 1 for a write frame, 0 for a read frame |
| mode_normal | input | 1 | Converter is in normal operating mode |
| sync_hold | input | 1 | Holds off conversion starts while high |
| acq_start | input | 1 | Acquisition-start strobe |
| acq_ch | input | 1 | Channel of the acquisition |
| act_off | output | 48 | Active offset words, channel 0 in the low bits |
| act_gain | output | 48 | Active gain words, channel 0 in the low bits |
| pending | output | 2 | Staged words are waiting, one bit per channel |
| discard | output | 2 | Current acquisition result is invalid, one bit per channel |

## Verification
The bench builds the block with its default parameters: 24-bit words and two channels. These values match the required frame length and the gain default of 0x800000. With two channels, every commit can be checked against a neighbour that must not change, which covers channel isolation. The 24-bit width also makes an early select release at bit 10 a clear partial frame, and it lets a full frame that follows confirm that the bit count was cleared.

// File: rtl/cal_bank.sv
module cal_bank #(
  parameter int W   = 24,
  parameter int NCH = 2,
  localparam int CW  = $clog2(W),
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_cs_n,
  input  logic             ser_stb,
  input  logic             ser_din,
  output logic             ser_dout,
  input  logic [CHW-1:0]   sel_ch,
  input  logic             sel_gain,
  input  logic             ser_wr,
  input  logic             mode_normal,
  input  logic             sync_hold,
  input  logic             acq_start,
  input  logic [CHW-1:0]   acq_ch,
  output logic [NCH*W-1:0] act_off,
  output logic [NCH*W-1:0] act_gain,
  output logic [NCH-1:0]   pending,
  output logic [NCH-1:0]   discard
);
  localparam logic [W-1:0] OFF_RST  = '0;
  localparam logic [W-1:0] GAIN_RST = {1'b1, {(W-1){1'b0}}};
  localparam logic [CW-1:0] LAST    = CW'(W-1);

  logic [W-1:0]  stg_off [NCH];
  logic [W-1:0]  stg_gain[NCH];
  logic [W-1:0]  cur_off [NCH];
  logic [W-1:0]  cur_gain[NCH];
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  new_word, rd_word;
  logic          wr_done, take;

  assign new_word = {shreg[W-2:0], ser_din};
  assign wr_done  = !ser_cs_n && ser_stb && (cnt == LAST) && ser_wr && mode_normal;
  assign take     = acq_start && !sync_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (ser_cs_n) begin
      cnt <= '0;
    end else if (ser_stb) begin
      shreg <= new_word;
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        stg_off[i]  <= OFF_RST;
        stg_gain[i] <= GAIN_RST;
        cur_off[i]  <= OFF_RST;
        cur_gain[i] <= GAIN_RST;
      end
      pending <= '0;
      discard <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_done && sel_ch == CHW'(i)) begin
          if (sel_gain) stg_gain[i] <= new_word;
          else          stg_off[i]  <= new_word;
        end
        if (take && acq_ch == CHW'(i)) begin
          discard[i] <= pending[i];
          if (pending[i]) begin
            cur_off[i]  <= stg_off[i];
            cur_gain[i] <= stg_gain[i];
          end
        end
        if (wr_done && sel_ch == CHW'(i))
          pending[i] <= 1'b1;
        else if (take && acq_ch == CHW'(i))
          pending[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (pending[sel_ch]) rd_word = sel_gain ? stg_gain[sel_ch] : stg_off[sel_ch];
    else                 rd_word = sel_gain ? cur_gain[sel_ch] : cur_off[sel_ch];
  end

  assign ser_dout = !ser_cs_n && rd_word[LAST - cnt];

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign act_off [g*W +: W] = cur_off[g];
    assign act_gain[g*W +: W] = cur_gain[g];
  end
endmodule

module cal_bank_chk #(
  parameter int W   = 24,
  parameter int NCH = 2,
  localparam int CW  = $clog2(W),
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_cs_n,
  input logic             ser_stb,
  input logic             ser_wr,
  input logic             mode_normal,
  input logic             sync_hold,
  input logic             acq_start,
  input logic [CHW-1:0]   acq_ch,
  input logic [CHW-1:0]   sel_ch,
  input logic [CW-1:0]    cnt,
  input logic [NCH*W-1:0] act_off,
  input logic [NCH*W-1:0] act_gain,
  input logic [NCH-1:0]   pending,
  input logic [NCH-1:0]   discard
);
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs_n |=> cnt == '0); // R3
  AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_cs_n && ser_stb && ser_wr && mode_normal && cnt == CW'(W-1)) |=> pending[$past(sel_ch)]); // R2
  AST_NO_WRITE_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_normal && !acq_start) |=> $stable(pending)); // R4
  AST_ACT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_start |=> ($stable(act_off) && $stable(act_gain))); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |=> ($stable(act_off) && $stable(act_gain) && $stable(discard))); // R6
  AST_DISCARD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_start && !sync_hold) |=> discard[$past(acq_ch)] == $past(pending[acq_ch])); // R7
endmodule

bind cal_bank cal_bank_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_stb(ser_stb),
  .ser_wr(ser_wr), .mode_normal(mode_normal), .sync_hold(sync_hold),
  .acq_start(acq_start), .acq_ch(acq_ch), .sel_ch(sel_ch), .cnt(cnt),
  .act_off(act_off), .act_gain(act_gain), .pending(pending), .discard(discard)
);

// File: tb/cal_bank_bench.sv
`timescale 1ns/1ps
module cal_bank_bench;
  localparam int W = 24;
  logic clk = 0, rst_n = 0;
  logic ser_cs_n = 1, ser_stb = 0, ser_din = 0, ser_dout;
  logic sel_ch = 0, sel_gain = 0, ser_wr = 0, mode_normal = 1, sync_hold = 0;
  logic acq_start = 0, acq_ch = 0;
  logic [2*W-1:0] act_off, act_gain;
  logic [1:0] pending, discard;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_bank u_cal_bank (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_stb(ser_stb),
    .ser_din(ser_din), .ser_dout(ser_dout), .sel_ch(sel_ch), .sel_gain(sel_gain),
    .ser_wr(ser_wr), .mode_normal(mode_normal), .sync_hold(sync_hold),
    .acq_start(acq_start), .acq_ch(acq_ch), .act_off(act_off), .act_gain(act_gain),
    .pending(pending), .discard(discard)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(bit ch, bit gain, bit wr, logic [W-1:0] word, int nbits,
                            output logic [W-1:0] got);
    got = '0;
    @(negedge clk);
    sel_ch = ch; sel_gain = gain; ser_wr = wr; ser_cs_n = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      got[W-1-i] = ser_dout;
      ser_din = word[W-1-i];
      ser_stb = 1;
      @(negedge clk);
      ser_stb = 0;
    end
    ser_cs_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(bit ch, bit gain, logic [W-1:0] word);
    logic [W-1:0] d;
    shift_word(ch, gain, 1, word, W, d);
  endtask

  task automatic rd(bit ch, bit gain, output logic [W-1:0] word);
    shift_word(ch, gain, 0, '0, W, word);
  endtask

  task automatic acq(bit ch, bit hold);
    @(negedge clk);
    acq_start = 1; acq_ch = ch; sync_hold = hold;
    @(negedge clk);
    acq_start = 0; sync_hold = 0;
  endtask

  task automatic t_reset;
    check("R1 off0", act_off[0 +: W], 0);
    check("R1 off1", act_off[W +: W], 0);
    check("R1 gain0", act_gain[0 +: W], 24'h800000);
    check("R1 gain1", act_gain[W +: W], 24'h800000);
    check("R1 flags", {pending, discard}, 0);
  endtask

  task automatic t_stage_and_commit;
    logic [W-1:0] r;
    wr(0, 0, 24'h123456);
    check("R2 pending", pending, 2'b01);
    check("R5 active held", act_off[0 +: W], 0);
    rd(0, 0, r);
    check("R8 staged readback", r, 24'h123456);
    acq(1, 0);
    check("R9 other pending", pending, 2'b01);
    check("R9 other active", act_off[0 +: W], 0);
    acq(0, 1);
    check("R6 hold active", act_off[0 +: W], 0);
    check("R6 hold pending", pending, 2'b01);
    acq(0, 0);
    check("R5 committed", act_off[0 +: W], 24'h123456);
    check("R7 discard set", discard, 2'b01);
    check("R7 pending cleared", pending, 2'b00);
    acq(0, 0);
    check("R7 discard cleared", discard, 2'b00);
    rd(0, 0, r);
    check("R8 active readback", r, 24'h123456);
  endtask

  task automatic t_short_write;
    logic [W-1:0] d;
    shift_word(1, 1, 1, 24'hFFFFFF, 10, d);
    check("R3 no pending", pending, 2'b00);
    wr(1, 1, 24'hA5C3E1);
    check("R3 fresh frame pending", pending, 2'b10);
    acq(1, 0);
    check("R3 fresh frame value", act_gain[W +: W], 24'hA5C3E1);
    check("R9 ch0 gain kept", act_gain[0 +: W], 24'h800000);
  endtask

  task automatic t_mode_ignore;
    logic [W-1:0] r;
    mode_normal = 0;
    wr(0, 1, 24'hFFFFFF);
    mode_normal = 1;
    check("R4 no pending", pending, 2'b00);
    rd(0, 1, r);
    check("R4 gain unchanged", r, 24'h800000);
    rd(1, 0, r);
    check("R8 default offset readback", r, 24'h000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stage_and_commit();
    t_short_write();
    t_mode_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule